// File: doc/BRIEF.md
# Variable Page-Size Translation Lookaside Buffer

This block is a small, fully associative address translation cache. Each slot holds a tag word and a data word. The tag word carries the virtual page, the page size, a valid flag and a keep flag. The data word carries the physical page plus endianness, element-size and mixed-page attributes. Every slot compares only the virtual address bits that its own page size covers, so 16 MB, 1 MB, 64 KB and 4 KB pages can sit side by side in the same array.

Software fills a slot by presenting a tag word, a data word and a slot index together with a one-cycle load strobe. A load whose virtual page is not aligned to its page size is refused and flagged. The lookup port takes a 32-bit virtual address and, one cycle later, reports exactly one outcome: a single hit with the translated address and attributes, a miss, or a multi-hit fault when more than one slot matches. Slots can be read back by index, flushed one at a time, or flushed globally. A global flush spares slots that carry the keep flag.

Top module: `vpage_tlb`

## Requirements
- R1: The tag field bits [1:0] select the page size: 0 = 16 MB (compare mask 0xFF000000), 1 = 1 MB (0xFFF00000), 2 = 64 KB (0xFFFF0000), 3 = 4 KB (0xFFFFF000). A valid slot matches when the lookup address equals the slot's virtual page (tag bits [31:12], low 12 bits zero) under that mask.
- R2: An accepted load always leaves the slot valid (tag bit 3), whatever bit 3 of the written tag word holds.
- R3: A load whose tag bits [31:12] have any bit set below the page mask is refused. `ld_err_o` is 1 in the cycle after the strobe, and the slot is left unchanged. An accepted load gives `ld_err_o` = 0.
- R4: On a hit, `rsp_pa_o` takes the bits inside the page mask from the slot's physical page (data bits [31:12]) and the bits outside the mask from the lookup address.
- R5: On a hit, `rsp_attr_o` equals data bits [3:0] of the matching slot: bit 3 mixed, bits [2:1] element size, bit 0 endianness.
- R6: A lookup that matches no valid slot gives `rsp_miss_o` = 1, with `rsp_pa_o` and `rsp_attr_o` both zero.
- R7: A lookup that matches two or more valid slots gives `rsp_multi_o` = 1, with `rsp_hit_o` = 0 and `rsp_pa_o` and `rsp_attr_o` both zero.
- R8: Reading back a slot returns its tag word and data word one cycle after `rd_idx_i`. The tag word holds the virtual page in [31:12], valid in [3], keep in [2] and size in [1:0]. The data word holds its fields as in R4 and R5. Bits [11:4] of both words read as zero.
- R9: A global flush clears the valid bit of every slot whose keep bit (tag bit 2) is 0, and leaves slots with keep set valid.
- R10: A single-slot flush clears the valid bit of the indexed slot even when its keep bit is set. The other fields of a flushed slot read back unchanged.
- R11: A lookup strobed in one cycle is answered in the next cycle with `rsp_valid_o` = 1 and exactly one of hit, miss or multi. Without a lookup, all response flags are 0.
- R12: After reset every slot reads back as all zeros, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb_i | input | 1 | Load strobe |
| ld_idx_i | input | 3 | Slot index for the load |
| ld_tag_i | input | 32 | Tag word to load |
| ld_data_i | input | 32 | Data word to load |
| ld_err_o | output | 1 | Misaligned load refused (registered) |
| gflush_i | input | 1 | Global flush of non-keep slots |
| eflush_i | input | 1 | Single-slot flush strobe |
| eflush_idx_i | input | 3 | Slot index for the single-slot flush |
| rd_idx_i | input | 3 | Readback slot index |
| rd_tag_o | output | 32 | Readback tag word |
| rd_data_o | output | 32 | Readback data word |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_va_i | input | 32 | Lookup virtual address |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Single matching slot |
| rsp_miss_o | output | 1 | No matching slot |
| rsp_multi_o | output | 1 | Multi-hit fault |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_attr_o | output | 4 | Attributes of the matching slot |

## Verification
The assertions check on every cycle that each response carries exactly one outcome and that a quiet cycle has no flags. They also check that accepted loads and flushes set or clear the valid bit, that a refused load leaves storage untouched, and that the untranslated low 12 address bits pass through on a hit. The bench scenarios cover the rest. They flip every address bit against a slot of each page size, which shows the size-dependent mask boundary and the splicing of the physical address. They overlap slots of different sizes to show the multi-hit fault. Mixes of keep flags and flushes show that global flushes spare keep slots while single-slot flushes do not.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;

  localparam int WORD_W = 32;
  localparam int PAGE_LSB = 12;

  typedef enum logic [1:0] {
    PG_16M = 2'd0,
    PG_1M  = 2'd1,
    PG_64K = 2'd2,
    PG_4K  = 2'd3
  } pgsz_e;

  typedef struct packed {
    logic [WORD_W-PAGE_LSB-1:0] vpage;
    logic [7:0]                 rsvd;
    logic                       valid;
    logic                       keep;
    pgsz_e                      size;
  } tag_t;

  typedef struct packed {
    logic [WORD_W-PAGE_LSB-1:0] ppage;
    logic [7:0]                 rsvd;
    logic                       mixed;
    logic [1:0]                 elsz;
    logic                       endian;
  } data_t;

  function automatic logic [WORD_W-1:0] page_mask(pgsz_e s);
    case (s)
      PG_16M:  page_mask = 32'hFF00_0000;
      PG_1M:   page_mask = 32'hFFF0_0000;
      PG_64K:  page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFFF_F000;
    endcase
  endfunction

endpackage

// File: rtl/vpage_tlb_entry.sv
module vpage_tlb_entry
  import vpage_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  tag_t              wr_tag,
  input  data_t             wr_data,
  input  logic              clr,
  input  logic [WORD_W-1:0] va,
  output tag_t              tag_q,
  output data_t             data_q,
  output logic [WORD_W-1:0] mask,
  output logic              hit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      tag_q       <= wr_tag;
      tag_q.valid <= 1'b1;
      tag_q.rsvd  <= '0;
      data_q      <= wr_data;
      data_q.rsvd <= '0;
    end else if (clr) begin
      tag_q.valid <= 1'b0;
    end
  end

  assign mask = page_mask(tag_q.size);
  assign hit  = tag_q.valid &&
                (((va ^ {tag_q.vpage, {PAGE_LSB{1'b0}}}) & mask) == '0);

  // R2: an accepted load leaves the slot valid
  a_r2_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tag_q.valid);

  // R9 / R10: a flush without a concurrent load drops the valid bit
  a_r10_clear_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> !tag_q.valid);

endmodule

// File: rtl/vpage_tlb_lookup.sv
module vpage_tlb_lookup
  import vpage_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = WORD_W - PAGE_LSB,
  parameter int ATTR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req,
  input  logic [WORD_W-1:0]               va,
  input  logic [ENTRIES-1:0]              hits,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  masks,
  input  logic [ENTRIES-1:0][PPN_W-1:0]   pages,
  input  logic [ENTRIES-1:0][ATTR_W-1:0]  attrs,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic                            rsp_miss,
  output logic                            rsp_multi,
  output logic [WORD_W-1:0]               rsp_pa,
  output logic [ATTR_W-1:0]               rsp_attr
);

  logic [WORD_W-1:0] sel_mask;
  logic [PPN_W-1:0]  sel_page;
  logic [ATTR_W-1:0] sel_attr;
  logic              none, several;
  logic [WORD_W-1:0] pa_nxt;

  always_comb begin
    sel_mask = '0;
    sel_page = '0;
    sel_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i]) begin
        sel_mask = sel_mask | masks[i];
        sel_page = sel_page | pages[i];
        sel_attr = sel_attr | attrs[i];
      end
    end
  end

  assign none    = (hits == '0);
  assign several = ((hits & (hits - 1'b1)) != '0);
  assign pa_nxt  = ({sel_page, {PAGE_LSB{1'b0}}} & sel_mask) | (va & ~sel_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= req;
      rsp_hit   <= req && !none && !several;
      rsp_miss  <= req && none;
      rsp_multi <= req && several;
      rsp_pa    <= (req && !none && !several) ? pa_nxt : '0;
      rsp_attr  <= (req && !none && !several) ? sel_attr : '0;
    end
  end

  // R11: each response has exactly one outcome
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_multi}) == 1));

  // R11: no flags without a response
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_multi));

  // R6 / R7: a non-hit response carries no address
  a_r7_no_pa_on_fault: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pa == '0 && rsp_attr == '0));

endmodule

// File: rtl/vpage_tlb_readback.sv
module vpage_tlb_readback
  import vpage_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    idx,
  input  tag_t  [ENTRIES-1:0] tags,
  input  data_t [ENTRIES-1:0] datas,
  output logic [WORD_W-1:0]   tag_word,
  output logic [WORD_W-1:0]   data_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_word  <= '0;
      data_word <= '0;
    end else if (int'(idx) < ENTRIES) begin
      tag_word  <= tags[idx];
      data_word <= datas[idx];
    end else begin
      tag_word  <= '0;
      data_word <= '0;
    end
  end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter  int ENTRIES = 8,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [31:0]       ld_tag_i,
  input  logic [31:0]       ld_data_i,
  output logic              ld_err_o,
  input  logic              gflush_i,
  input  logic              eflush_i,
  input  logic [IDX_W-1:0]  eflush_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [31:0]       rd_tag_o,
  output logic [31:0]       rd_data_o,
  input  logic              lk_valid_i,
  input  logic [31:0]       lk_va_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_multi_o,
  output logic [31:0]       rsp_pa_o,
  output logic [3:0]        rsp_attr_o
);

  localparam int PPN_W  = WORD_W - PAGE_LSB;
  localparam int ATTR_W = 4;

  tag_t  new_tag;
  data_t new_data;
  logic  misaligned;

  tag_t  [ENTRIES-1:0]              ent_tag;
  data_t [ENTRIES-1:0]              ent_data;
  logic  [ENTRIES-1:0][WORD_W-1:0]  ent_mask;
  logic  [ENTRIES-1:0][PPN_W-1:0]   ent_page;
  logic  [ENTRIES-1:0][ATTR_W-1:0]  ent_attr;
  logic  [ENTRIES-1:0]              ent_hit;
  logic  [ENTRIES-1:0]              ent_wr;
  logic  [ENTRIES-1:0]              ent_clr;

  assign new_tag    = ld_tag_i;
  assign new_data   = ld_data_i;
  assign misaligned = (({new_tag.vpage, {PAGE_LSB{1'b0}}} &
                        ~page_mask(new_tag.size)) != '0);

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      assign ent_wr[i]  = ld_stb_i && !misaligned && (ld_idx_i == IDX_W'(i));
      assign ent_clr[i] = (eflush_i && (eflush_idx_i == IDX_W'(i))) ||
                          (gflush_i && !ent_tag[i].keep);
      assign ent_page[i] = ent_data[i].ppage;
      assign ent_attr[i] = {ent_data[i].mixed, ent_data[i].elsz, ent_data[i].endian};

      vpage_tlb_entry u_entry (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ent_wr[i]),
        .wr_tag  (new_tag),
        .wr_data (new_data),
        .clr     (ent_clr[i]),
        .va      (lk_va_i),
        .tag_q   (ent_tag[i]),
        .data_q  (ent_data[i]),
        .mask    (ent_mask[i]),
        .hit     (ent_hit[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ld_err_o <= 1'b0;
    else     ld_err_o <= ld_stb_i && misaligned;
  end

  vpage_tlb_lookup #(
    .ENTRIES (ENTRIES),
    .PPN_W   (PPN_W),
    .ATTR_W  (ATTR_W)
  ) u_lookup (
    .clk       (clk),
    .rst       (rst),
    .req       (lk_valid_i),
    .va        (lk_va_i),
    .hits      (ent_hit),
    .masks     (ent_mask),
    .pages     (ent_page),
    .attrs     (ent_attr),
    .rsp_valid (rsp_valid_o),
    .rsp_hit   (rsp_hit_o),
    .rsp_miss  (rsp_miss_o),
    .rsp_multi (rsp_multi_o),
    .rsp_pa    (rsp_pa_o),
    .rsp_attr  (rsp_attr_o)
  );

  vpage_tlb_readback #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .idx       (rd_idx_i),
    .tags      (ent_tag),
    .datas     (ent_data),
    .tag_word  (rd_tag_o),
    .data_word (rd_data_o)
  );

  // R3: a refused load leaves the storage untouched when no flush ran alongside
  a_r3_refused_no_write: assert property (@(posedge clk) disable iff (rst)
    (ld_err_o && !$past(gflush_i) && !$past(eflush_i)) |-> $stable(ent_tag));

  // R4: the 12 offset bits always come from the lookup address
  a_r4_offset_passthru: assert property (@(posedge clk) disable iff (rst)
    rsp_hit_o |-> (rsp_pa_o[11:0] == $past(lk_va_i[11:0])));

  // R9: a global flush spares slots marked keep
  a_r9_keep_survives: assert property (@(posedge clk) disable iff (rst)
    (gflush_i && !eflush_i && !ld_stb_i && ent_tag[0].keep && ent_tag[0].valid)
      |=> ent_tag[0].valid);

endmodule

// File: tb/tb_vpage_tlb.sv
`timescale 1ns/1ps
module tb_vpage_tlb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_stb_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [31:0] ld_tag_i = '0;
  logic [31:0] ld_data_i = '0;
  logic        ld_err_o;
  logic        gflush_i = 1'b0;
  logic        eflush_i = 1'b0;
  logic [2:0]  eflush_idx_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [31:0] rd_tag_o, rd_data_o;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_multi_o;
  logic [31:0] rsp_pa_o;
  logic [3:0]  rsp_attr_o;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_tag  [8];
  logic [31:0] m_data [8];

  always #4 clk = ~clk;

  vpage_tlb dut (.*);

  function automatic logic [31:0] bmask(logic [1:0] s);
    case (s)
      2'd0: return 32'hFF00_0000;
      2'd1: return 32'hFFF0_0000;
      2'd2: return 32'hFFFF_0000;
      default: return 32'hFFFF_F000;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_load(int idx, logic [31:0] tag, logic [31:0] data);
    logic bad;
    bad = (({tag[31:12], 12'h000} & ~bmask(tag[1:0])) != 0);
    ld_stb_i = 1'b1; ld_idx_i = 3'(idx); ld_tag_i = tag; ld_data_i = data;
    @(negedge clk);
    ld_stb_i = 1'b0;
    check(bad ? "R3 load refused flag" : "R3 load accepted flag",
          32'(ld_err_o), 32'(bad));
    if (!bad) begin
      m_tag[idx]  = (tag & 32'hFFFF_F007) | 32'h8;   // R2: valid forced
      m_data[idx] = data & 32'hFFFF_F00F;
    end
  endtask

  task automatic do_read(int idx, string req);
    rd_idx_i = 3'(idx);
    @(negedge clk);
    check({req, " tag readback"}, rd_tag_o, m_tag[idx]);
    check({req, " data readback"}, rd_data_o, m_data[idx]);
  endtask

  task automatic do_gflush();
    gflush_i = 1'b1;
    @(negedge clk);
    gflush_i = 1'b0;
    for (int i = 0; i < 8; i++)
      if (!m_tag[i][2]) m_tag[i][3] = 1'b0;
  endtask

  task automatic do_eflush(int idx);
    eflush_i = 1'b1; eflush_idx_i = 3'(idx);
    @(negedge clk);
    eflush_i = 1'b0;
    m_tag[idx][3] = 1'b0;
  endtask

  task automatic do_lookup(logic [31:0] va, string req);
    int cnt;
    int who;
    logic [31:0] m, epa;
    logic [3:0] eat;
    cnt = 0; who = 0;
    for (int i = 0; i < 8; i++) begin
      m = bmask(m_tag[i][1:0]);
      if (m_tag[i][3] && ((va & m) == ({m_tag[i][31:12], 12'h000} & m))) begin
        cnt++; who = i;
      end
    end
    epa = 0; eat = 0;
    if (cnt == 1) begin
      m = bmask(m_tag[who][1:0]);
      epa = (m_data[who] & m) | (va & ~m);
      eat = m_data[who][3:0];
    end
    lk_valid_i = 1'b1; lk_va_i = va;
    @(negedge clk);
    lk_valid_i = 1'b0;
    check({req, " R11 valid/hit/miss/multi"},
          {28'h0, rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_multi_o},
          {28'h0, 1'b1, cnt == 1, cnt == 0, cnt > 1});
    check({req, " R4 pa"}, rsp_pa_o, epa);
    check({req, " R5 attr"}, 32'(rsp_attr_o), 32'(eat));
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] base, tag;
    for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12 reset outputs",
          {26'h0, rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_multi_o, ld_err_o, 1'b0},
          32'h0);
    check("R12 reset pa", rsp_pa_o, 32'h0);
    for (int i = 0; i < 8; i++) do_read(i, "R12");
    do_lookup(32'h0000_0000, "R6 R12 empty");

    // R1 R2 R4 R5: sweep every address bit against each page size
    for (int s = 0; s < 4; s++) begin
      do_gflush();
      base = 32'h5A5A_5000 & bmask(2'(s));
      do_load(s * 2 + 1, base | 32'(s), 32'hC3E7_1000 | 32'((s * 5 + 3) & 15));
      do_read(s * 2 + 1, "R1 R2");
      for (int b = 0; b < 32; b++)
        do_lookup((base | 32'h0000_0ABC) ^ (32'h1 << b), "R1 sweep");
    end

    // R3: misaligned loads are refused and leave the slot untouched
    do_gflush();
    for (int s = 0; s < 3; s++) begin
      tag = (32'h1234_5000 & bmask(2'(s))) | 32'h0000_1000 | 32'(s);
      do_load(7, tag, 32'hFFFF_F00F);
      do_read(7, "R3 unchanged");
    end
    do_load(7, 32'h1234_5003, 32'h0ABC_D005);
    do_read(7, "R3 aligned 4K");

    // R7: overlapping pages of different sizes
    do_gflush();
    do_load(1, 32'h4000_0000, 32'h7700_0002);
    do_load(5, 32'h4012_3003, 32'h0055_5009);
    do_lookup(32'h4012_3456, "R7 multi");
    do_lookup(32'h4020_0000, "R7 single");
    do_lookup(32'h4100_0000, "R6 miss");

    // R9 R10: keep flags against global and single flushes
    do_load(2, 32'h8000_0005, 32'h1230_000E);
    do_load(3, 32'h9000_0002, 32'h2340_0001);
    do_gflush();
    for (int i = 0; i < 8; i++) do_read(i, "R9");
    do_lookup(32'h8001_2345, "R9 keep hit");
    do_lookup(32'h9000_0000, "R9 flushed miss");
    do_eflush(2);
    do_read(2, "R10");
    do_lookup(32'h8001_2345, "R10 flushed miss");
    do_load(0, 32'hFFFF_F00B, 32'hA5A5_A00D);
    do_lookup(32'hFFFF_F123, "R2 R4 top page");
    for (int i = 0; i < 8; i++) do_read(i, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule